// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the decision core of an eight-input interrupt controller. It keeps three per-input state vectors: pending requests, requests in service, and a mask. Each input line is latched either on a rising transition or as a level, according to a per-input trigger-mode vector. Every cycle the block finds the best unmasked pending request. The search starts at a rotating priority base and walks upward modulo the input count. The block raises a registered interrupt output when that request ranks strictly better than anything already in service.

An acknowledge strobe moves the winning input into service and returns a vector one cycle later. The vector is a programmable upper field joined with the three-bit input number. When nothing wins, the input number 7 is used instead, as a spurious code. The surrounding register decoder drives single-cycle strobes for end-of-interrupt (either the top in-service entry or a named one, each with an optional rotation), for setting the priority base, for writing the mask and for re-initialising. Static mode inputs select automatic end-of-interrupt, rotation on automatic end-of-interrupt, and a nested mode in which the cascade input's in-service bit is left out of the comparison.

When several strobes arrive in the same cycle, one of them takes effect, in this order: re-initialise, acknowledge, end-of-interrupt on the top entry, end-of-interrupt on a named entry, set base. A mask write applies alongside any of them except re-initialise.

Top module: `rpir_top`

## Requirements
- R1: For an input with `trig_lvl`=0, the request bit (`irr_o`) sets only when the line is high and was low at the previous clock edge. A line held high does not set the request bit again after an acknowledge has cleared it.
- R2: For an input with `trig_lvl`=1, the request bit follows the line at every clock edge. An acknowledge leaves it set while the line stays high.
- R3: The winner is the first unmasked pending input met when counting upward modulo 8 from the priority base. The base is 0 after reset.
- R4: `int_req` is high one clock after a state in which the winner's rank (its distance from the base) is strictly smaller than the rank of the best in-service bit. An empty in-service set counts as rank 8.
- R5: An input whose `imr_o` bit is 1 never wins and never causes `int_req`.
- R6: On `ack` with a winner, the winner's `isr_o` bit is set. `vec_valid` pulses in the next cycle, with `vec_out` = {`vec_base`, input number} (input number in bits 2:0).
- R7: On `ack` with no winner, `vec_out` = {`vec_base`, 3'b111} and the request and in-service state are left unchanged.
- R8: With `auto_eoi`=1 an acknowledge leaves the winner's `isr_o` bit clear. If `rot_aeoi`=1 as well, the base becomes winner+1 modulo 8.
- R9: `eoi_top` clears the best-ranked `isr_o` bit. With `eoi_rot`=1 it also sets the base to that input+1 modulo 8.
- R10: `eoi_sel` clears `isr_o[cmd_lvl]`. `base_set` sets the base to `cmd_lvl`+1 modulo 8, which makes `cmd_lvl` the lowest priority.
- R11: With `sfnm_en`=1, the in-service bit of cascade input 2 is ignored in the `int_req` comparison.
- R12: `reinit` clears `isr_o`, `imr_o`, the base and the line history, and keeps only the `irr_o` bits of inputs with `trig_lvl`=1. An active `rst_n` clears all state at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 8 | Interrupt input lines |
| trig_lvl | input | 8 | Trigger mode per input, 1 = level, 0 = rising edge |
| imr_wr | input | 1 | Mask write strobe |
| imr_wdata | input | 8 | New mask value |
| eoi_top | input | 1 | End-of-interrupt for the best-ranked in-service bit |
| eoi_sel | input | 1 | End-of-interrupt for input `cmd_lvl` |
| eoi_rot | input | 1 | Rotate the base on either end-of-interrupt strobe |
| base_set | input | 1 | Set the priority base from `cmd_lvl` |
| cmd_lvl | input | 3 | Input number for `eoi_sel` and `base_set` |
| auto_eoi | input | 1 | Automatic end-of-interrupt mode |
| rot_aeoi | input | 1 | Rotate the base on automatic end-of-interrupt |
| sfnm_en | input | 1 | Nested mode that ignores the cascade in-service bit |
| reinit | input | 1 | Re-initialisation strobe |
| vec_base | input | 5 | Upper field of the returned vector |
| ack | input | 1 | Acknowledge strobe |
| int_req | output | 1 | Registered interrupt request |
| vec_valid | output | 1 | Vector valid, one cycle after `ack` |
| vec_out | output | 8 | Returned vector |
| irr_o | output | 8 | Pending request state |
| isr_o | output | 8 | In-service state |
| imr_o | output | 8 | Mask state |

## Verification
The bench builds the block with its defaults: eight inputs, an 8-bit vector, the master variant, and cascade input 2. The master variant makes the nested-mode exclusion of input 2 reachable. Eight inputs let a short run walk the base across the wrap from 7 to 0, reach the spurious code 7, and set the base from `cmd_lvl`=7. Vectors go through a scoreboard that matches each acknowledge to its expected code. Direct checks follow the request, in-service and mask state through edge and level latching, rotation, nesting and re-initialisation.

// File: rtl/rpir_pkg.sv
package rpir_pkg;

  // Operation applied to the in-service and base state in one cycle.
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_ACK,
    OP_EOI_TOP,
    OP_EOI_SEL,
    OP_SET_BASE,
    OP_REINIT
  } rpir_op_e;

endpackage

// File: rtl/rpir_rank.sv
// Distance from the base to the first set bit, counting upward with wrap.
// Returns N when no bit is set.
module rpir_rank #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  bits_i,
  input  logic [LW-1:0] base_i,
  output logic [LW:0]   rank_o
);

  always_comb begin
    rank_o = (LW+1)'(N);
    for (int p = N - 1; p >= 0; p--) begin
      if (bits_i[base_i + LW'(p)]) rank_o = (LW+1)'(p);
    end
  end

endmodule

// File: rtl/rpir_latch.sv
// Per-input request capture: level inputs copy the line, edge inputs
// keep the held value and add a rising transition.
module rpir_latch #(
  parameter int N = 8
) (
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] last_i,
  input  logic [N-1:0] held_i,
  output logic [N-1:0] irr_o
);

  for (genvar i = 0; i < N; i++) begin : g_in
    assign irr_o[i] = lvl_i[i] ? line_i[i]
                               : (held_i[i] | (line_i[i] & ~last_i[i]));
  end

endmodule

// File: rtl/rpir_top.sv
module rpir_top
  import rpir_pkg::*;
#(
  parameter int N          = 8,
  parameter int VEC_W      = 8,
  parameter int IS_MASTER  = 1,
  parameter int CASCADE_IN = 2,
  localparam int LW        = $clog2(N),
  localparam int VB_W      = VEC_W - LW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    irq_in,
  input  logic [N-1:0]    trig_lvl,
  input  logic            imr_wr,
  input  logic [N-1:0]    imr_wdata,
  input  logic            eoi_top,
  input  logic            eoi_sel,
  input  logic            eoi_rot,
  input  logic            base_set,
  input  logic [LW-1:0]   cmd_lvl,
  input  logic            auto_eoi,
  input  logic            rot_aeoi,
  input  logic            sfnm_en,
  input  logic            reinit,
  input  logic [VB_W-1:0] vec_base,
  input  logic            ack,
  output logic            int_req,
  output logic            vec_valid,
  output logic [VEC_W-1:0] vec_out,
  output logic [N-1:0]    irr_o,
  output logic [N-1:0]    isr_o,
  output logic [N-1:0]    imr_o
);

  localparam logic [N-1:0] CASC_BIT = N'(1) << CASCADE_IN;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rsync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  // State
  logic [N-1:0]     irr_q, isr_q, imr_q, last_q;
  logic [LW-1:0]    base_q;
  logic             int_q, vv_q;
  logic [VEC_W-1:0] vec_q;

  // Next state
  logic [N-1:0]     irr_n, isr_n, imr_n, last_n, irr_clr, irr_lat;
  logic [LW-1:0]    base_n;
  logic             int_n, imr_en;
  logic [VEC_W-1:0] vec_n;
  rpir_op_e         op;

  // Resolution
  logic [N-1:0]  req_bits, cmp_bits, casc_excl;
  logic [LW:0]   req_rank, cmp_rank, top_rank;
  logic [LW-1:0] win_idx, top_idx;
  logic          win_found, win_valid, top_found;

  if (IS_MASTER != 0) begin : g_master
    assign casc_excl = sfnm_en ? CASC_BIT : '0;
  end else begin : g_slave
    assign casc_excl = '0;
  end

  assign req_bits = irr_q & ~imr_q;
  assign cmp_bits = isr_q & ~casc_excl;

  rpir_rank #(.N(N), .LW(LW)) u_req_rank (
    .bits_i (req_bits),
    .base_i (base_q),
    .rank_o (req_rank)
  );

  rpir_rank #(.N(N), .LW(LW)) u_cmp_rank (
    .bits_i (cmp_bits),
    .base_i (base_q),
    .rank_o (cmp_rank)
  );

  rpir_rank #(.N(N), .LW(LW)) u_top_rank (
    .bits_i (isr_q),
    .base_i (base_q),
    .rank_o (top_rank)
  );

  assign win_found = ~req_rank[LW];
  assign win_idx   = base_q + req_rank[LW-1:0];
  assign win_valid = win_found && (req_rank < cmp_rank);
  assign top_found = ~top_rank[LW];
  assign top_idx   = base_q + top_rank[LW-1:0];

  // Operation select by fixed precedence
  always_comb begin
    if (reinit)        op = OP_REINIT;
    else if (ack)      op = OP_ACK;
    else if (eoi_top)  op = OP_EOI_TOP;
    else if (eoi_sel)  op = OP_EOI_SEL;
    else if (base_set) op = OP_SET_BASE;
    else               op = OP_IDLE;
  end

  rpir_latch #(.N(N)) u_latch (
    .line_i (irq_in),
    .lvl_i  (trig_lvl),
    .last_i (last_q),
    .held_i (irr_lat),
    .irr_o  (irr_n_lat)
  );

  logic [N-1:0] irr_n_lat;

  assign irr_lat = irr_q & ~irr_clr;

  always_comb begin
    irr_clr = '0;
    isr_n   = isr_q;
    base_n  = base_q;
    imr_en  = imr_wr;
    imr_n   = imr_wdata;
    last_n  = irq_in;
    int_n   = win_valid;
    vec_n   = {vec_base, {LW{1'b1}}};
    if (win_valid) vec_n = {vec_base, win_idx};

    unique case (op)
      OP_ACK: begin
        if (win_valid) begin
          if (!trig_lvl[win_idx]) irr_clr[win_idx] = 1'b1;
          if (auto_eoi) begin
            if (rot_aeoi) base_n = win_idx + LW'(1);
          end else begin
            isr_n[win_idx] = 1'b1;
          end
        end
      end
      OP_EOI_TOP: begin
        if (top_found) begin
          isr_n[top_idx] = 1'b0;
          if (eoi_rot) base_n = top_idx + LW'(1);
        end
      end
      OP_EOI_SEL: begin
        isr_n[cmd_lvl] = 1'b0;
        if (eoi_rot) base_n = cmd_lvl + LW'(1);
      end
      OP_SET_BASE: base_n = cmd_lvl + LW'(1);
      OP_REINIT: begin
        isr_n  = '0;
        base_n = '0;
        imr_en = 1'b1;
        imr_n  = '0;
        last_n = '0;
        int_n  = 1'b0;
      end
      default: ;
    endcase

    if (op == OP_REINIT) irr_n = irr_q & trig_lvl;
    else                 irr_n = irr_n_lat;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      irr_q  <= '0;
      isr_q  <= '0;
      imr_q  <= '0;
      last_q <= '0;
      base_q <= '0;
      int_q  <= 1'b0;
      vv_q   <= 1'b0;
      vec_q  <= '0;
    end else begin
      irr_q  <= irr_n;
      isr_q  <= isr_n;
      last_q <= last_n;
      base_q <= base_n;
      int_q  <= int_n;
      vv_q   <= ack;
      if (imr_en) imr_q <= imr_n;
      if (ack)    vec_q <= vec_n;
    end
  end

  assign int_req   = int_q;
  assign vec_valid = vv_q;
  assign vec_out   = vec_q;
  assign irr_o     = irr_q;
  assign isr_o     = isr_q;
  assign imr_o     = imr_q;

endmodule

// File: rtl/rpir_checker.sv
module rpir_checker #(
  parameter int N     = 8,
  parameter int VEC_W = 8,
  localparam int LW   = $clog2(N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack,
  input logic             reinit,
  input logic             auto_eoi,
  input logic             sfnm_en,
  input logic             win_valid,
  input logic             win_found,
  input logic [LW-1:0]    win_idx,
  input logic [LW-1:0]    base_q,
  input logic             int_req,
  input logic             vec_valid,
  input logic [VEC_W-1:0] vec_out,
  input logic [N-1:0]     irr_o,
  input logic [N-1:0]     isr_o,
  input logic [N-1:0]     imr_o
);

  // R4: a raised request needs a pending unmasked input one cycle earlier
  a_r4_int_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> $past(|(irr_o & ~imr_o)));

  // R5: the resolved winner is never a masked input
  a_r5_winner_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    win_found |-> !imr_o[win_idx]);

  // R6: every acknowledge is answered in the next cycle
  a_r6_vec_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vec_valid);

  // R6: a served winner lands in service
  a_r6_winner_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && win_valid && !auto_eoi && !reinit) |=> isr_o[$past(win_idx)]);

  // R7: an empty acknowledge yields the spurious code
  a_r7_spurious_code: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !win_valid) |=> (vec_out[LW-1:0] == {LW{1'b1}}));

  // R8: automatic end-of-interrupt leaves the winner out of service
  a_r8_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && win_valid && auto_eoi && !sfnm_en && !reinit)
      |=> !isr_o[$past(win_idx)]);

  // R12: re-initialise empties service, mask and base
  a_r12_reinit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> (isr_o == '0 && imr_o == '0 && base_q == '0));

endmodule

bind rpir_top rpir_checker #(.N(N), .VEC_W(VEC_W)) u_rpir_checker (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .ack       (ack),
  .reinit    (reinit),
  .auto_eoi  (auto_eoi),
  .sfnm_en   (sfnm_en),
  .win_valid (win_valid),
  .win_found (win_found),
  .win_idx   (win_idx),
  .base_q    (base_q),
  .int_req   (int_req),
  .vec_valid (vec_valid),
  .vec_out   (vec_out),
  .irr_o     (irr_o),
  .isr_o     (isr_o),
  .imr_o     (imr_o)
);

// File: tb/test_rpir_top.sv
module test_rpir_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0, trig_lvl = '0, imr_wdata = '0;
  logic       imr_wr = 0, eoi_top = 0, eoi_sel = 0, eoi_rot = 0, base_set = 0;
  logic [2:0] cmd_lvl = '0;
  logic       auto_eoi = 0, rot_aeoi = 0, sfnm_en = 0, reinit = 0, ack = 0;
  logic [4:0] vec_base = 5'h0C;
  logic       int_req, vec_valid;
  logic [7:0] vec_out, irr_o, isr_o, imr_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  rpir_top i_rpir_top (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig_lvl(trig_lvl),
    .imr_wr(imr_wr), .imr_wdata(imr_wdata), .eoi_top(eoi_top),
    .eoi_sel(eoi_sel), .eoi_rot(eoi_rot), .base_set(base_set),
    .cmd_lvl(cmd_lvl), .auto_eoi(auto_eoi), .rot_aeoi(rot_aeoi),
    .sfnm_en(sfnm_en), .reinit(reinit), .vec_base(vec_base), .ack(ack),
    .int_req(int_req), .vec_valid(vec_valid), .vec_out(vec_out),
    .irr_o(irr_o), .isr_o(isr_o), .imr_o(imr_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: issue an acknowledge and push the expected vector
  task automatic do_ack(string req, logic [7:0] exp);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    ack = 1; tick(1); ack = 0;
  endtask

  task automatic do_eoi_top(logic rot);
    eoi_top = 1; eoi_rot = rot; tick(1); eoi_top = 0; eoi_rot = 0;
  endtask

  task automatic do_eoi_sel(logic [2:0] lvl);
    eoi_sel = 1; cmd_lvl = lvl; tick(1); eoi_sel = 0;
  endtask

  task automatic do_base(logic [2:0] lvl);
    base_set = 1; cmd_lvl = lvl; tick(1); base_set = 0;
  endtask

  task automatic do_mask(logic [7:0] m);
    imr_wr = 1; imr_wdata = m; tick(1); imr_wr = 0;
  endtask

  // Monitor: compare each produced vector against the scoreboard
  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R6 unexpected vector actual=%0h expected=none", vec_out);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, {24'd0, vec_out}, {24'd0, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3); rst_n = 1; tick(3);
    // R12 reset state
    check("R12 reset irr", irr_o, 0);
    check("R12 reset isr", isr_o, 0);
    check("R4 reset int_req", int_req, 0);

    // R1 edge input 3
    irq_in[3] = 1; tick(1);
    check("R1 rise sets irr", irr_o, 8'h08);
    tick(1);
    check("R4 int_req on request", int_req, 1);
    do_ack("R6 vector input 3", 8'h63);
    check("R6 isr set", isr_o, 8'h08);
    check("R1 ack clears edge irr", irr_o, 8'h00);
    tick(3);
    check("R1 held high no retrigger", irr_o, 8'h00);
    check("R4 nothing pending", int_req, 0);
    do_eoi_top(0);
    check("R9 eoi clears top", isr_o, 8'h00);
    irq_in[3] = 0;

    // R2 level input 5
    trig_lvl[5] = 1; irq_in[5] = 1; tick(1);
    check("R2 level sets irr", irr_o, 8'h20);
    tick(1);
    do_ack("R6 vector input 5", 8'h65);
    check("R2 level stays pending", irr_o, 8'h20);
    tick(1);
    check("R4 equal rank gives no request", int_req, 0);
    irq_in[5] = 0; tick(1);
    check("R2 level follows low", irr_o, 8'h00);
    do_eoi_sel(3'd5);
    check("R10 eoi_sel clears named", isr_o, 8'h00);

    // R3 rotation from base 5
    do_base(3'd4);
    irq_in[1] = 1; irq_in[6] = 1; tick(2);
    do_ack("R3 rotated winner 6", 8'h66);
    do_eoi_top(0);
    do_ack("R3 next winner 1", 8'h61);
    do_eoi_top(0);
    irq_in[1] = 0; irq_in[6] = 0; tick(1);

    // R5 mask, R7 spurious
    do_mask(8'h02);
    irq_in[1] = 1; tick(2);
    check("R5 masked pending", irr_o, 8'h02);
    check("R5 masked no int_req", int_req, 0);
    do_ack("R7 spurious vector", 8'h67);
    check("R7 isr unchanged", isr_o, 8'h00);
    check("R7 irr unchanged", irr_o, 8'h02);
    do_mask(8'h00);
    tick(1);
    check("R5 unmask raises int_req", int_req, 1);
    do_ack("R5 unmasked winner 1", 8'h61);
    do_eoi_top(0);
    irq_in[1] = 0;

    // R4/R9 nesting with base 5
    irq_in[7] = 1; tick(2);
    do_ack("R4 vector 7", 8'h67);
    irq_in[6] = 1; tick(2);
    check("R4 better rank nests", int_req, 1);
    do_ack("R4 vector 6", 8'h66);
    check("R4 two in service", isr_o, 8'hC0);
    do_eoi_top(0);
    check("R9 top cleared first", isr_o, 8'h80);
    do_eoi_top(1);
    check("R9 last cleared", isr_o, 8'h00);
    irq_in[6] = 0; irq_in[7] = 0; tick(1);
    irq_in[0] = 1; irq_in[7] = 1; tick(1);
    do_ack("R9 rotated base 0 picks 0", 8'h60);
    do_eoi_top(0);
    do_ack("R9 then 7", 8'h67);
    do_eoi_top(0);
    irq_in[0] = 0; irq_in[7] = 0; tick(1);

    // R8 auto end-of-interrupt with rotation
    auto_eoi = 1; rot_aeoi = 1;
    irq_in[2] = 1; tick(1);
    do_ack("R8 vector 2", 8'h62);
    check("R8 isr stays clear", isr_o, 8'h00);
    irq_in[1] = 1; irq_in[4] = 1; tick(1);
    do_ack("R8 base 3 picks 4", 8'h64);
    do_ack("R8 base 5 picks 1", 8'h61);
    auto_eoi = 0; rot_aeoi = 0;
    irq_in[1] = 0; irq_in[2] = 0; irq_in[4] = 0; tick(1);

    // R11 nested mode on cascade input
    do_base(3'd7);
    sfnm_en = 1;
    irq_in[2] = 1; tick(1);
    do_ack("R11 vector 2", 8'h62);
    irq_in[2] = 0; tick(1);
    irq_in[2] = 1; tick(1);
    check("R11 cascade pending again", irr_o, 8'h04);
    tick(1);
    check("R11 excluded in-service", int_req, 1);
    sfnm_en = 0; tick(2);
    check("R11 off blocks request", int_req, 0);
    do_eoi_sel(3'd2);
    do_ack("R11 vector 2 again", 8'h62);
    do_eoi_top(0);
    irq_in[2] = 0; tick(1);

    // R12 re-initialise and async reset
    trig_lvl = 8'h10; irq_in[3] = 1; irq_in[4] = 1; tick(1);
    check("R12 both pending", irr_o, 8'h18);
    do_mask(8'h01);
    reinit = 1; tick(1); reinit = 0;
    check("R12 keeps level irr", irr_o, 8'h10);
    check("R12 mask cleared", imr_o, 8'h00);
    check("R12 isr cleared", isr_o, 8'h00);
    rst_n = 0; #1;
    check("R12 async reset irr", irr_o, 8'h00);
    irq_in = '0;
    tick(2); rst_n = 1; tick(3);

    check("R6 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule